// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block serialises one character at a time onto an asynchronous line. A character of one to eight data bits is taken from a parallel input through a valid/ready handshake. It goes out as a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. The stop period is not limited to whole bits: it is set in sixteenths of a bit time, from 1/16 up to two full bits.

Timing comes from a single oversampling clock enable, `os_tick`, which pulses at 16, 32 or 64 times the bit rate. The block measures every bit and every stop step by counting those pulses. A break request holds the line low for as long as it stays asserted. A character already in flight is finished first, including its complete stop period.

The configuration fields are sampled when a character is accepted and held for that whole character. The control path is a six-state machine:
- IDLE: the line is high and the block is ready.
- START: the start bit.
- DATA: one data bit per bit time.
- PARITY: the parity bit.
- STOP: the stop period.
- BREAK: the line is held low.

The transitions are:
- IDLE to START on an accepted character.
- IDLE to BREAK on a break request.
- START to DATA after one bit time.
- DATA to DATA for each further data bit.
- DATA to PARITY after the last data bit when parity is on, and DATA to STOP when it is off.
- PARITY to STOP after one bit time.
- STOP to IDLE when the stop period ends, or STOP to BREAK if break is requested at that point.
- BREAK to IDLE when the request is released.

Top module: `async_char_tx`

## Requirements
- R1: After reset the line `txd` is high, `busy` is low and `in_ready` is high.
- R2: An accepted character drives `txd` low from the next cycle for one bit time, then sends `cfg_char_len`+1 data bits (code 0 means 1 bit, code 7 means 8 bits), least significant bit first, each for one bit time.
- R3: `cfg_parity` selects the parity bit sent after the data: 1 odd (data plus parity holds an odd count of ones), 2 even, 3 mark (always 1), 4 space (always 0). Codes 0, 5, 6 and 7 send no parity bit.
- R4: The stop period is high and lasts `cfg_stop_len`+1 sixteenths of a bit time. Code 0 gives 1/16 of a bit and code 31 gives two bits.
- R5: `cfg_os_rate` gives the number of `os_tick` pulses per bit: 0 is 16, 1 is 32, 2 and 3 are 64. One stop step is always 1/16 of the bit time at the chosen rate.
- R6: `in_ready` is high only while idle with no break request. It rises in the cycle right after the stop period ends, so the next character is not accepted earlier.
- R7: The line advances only on cycles where `os_tick` is high. Without pulses the line holds its level.
- R8: A break request while idle drives `txd` low and `busy` high from the next cycle. It blocks acceptance of characters while asserted, and the line returns high with the block ready in the cycle after the request is released.
- R9: A break requested during a character lets that character and its full stop period complete unchanged. The line then goes low.
- R10: Configuration changes after acceptance do not affect the character in progress.
- R11: `busy` is high whenever the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling clock enable |
| cfg_os_rate | input | 2 | Oversampling rate select |
| cfg_char_len | input | 3 | Data bits per character minus one |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop_len | input | 5 | Stop period in sixteenths minus one |
| brk_req | input | 1 | Break request, line held low while high |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character taken when high with in_valid |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Block is not idle |

## Verification
Characters are swept over every data length crossed with every parity code. The data values are chosen so that both parity results occur, which separates a correct length count and LSB-first order from an off-by-one or reversed shift. A second sweep walks all 32 stop codes at one length, which separates a correct sixteenth scaling from a whole-bit or missing-step count. Frames at the 32x and 64x rates and with rate code 3 distinguish the scaling of the bit and stop steps from the 16x case. Further runs cover a gap in the oversampling pulses, configuration changes in mid-character, and break raised at idle and during a character; these tell enable gating, the configuration snapshot and the break ordering apart from their likely faults.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_BREAK  = 3'd5
    } tx_state_e;

    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

endpackage

// File: rtl/async_tx_parity.sv
module async_tx_parity #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CODE_W-1:0] len_code,
    input  logic [2:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    import async_tx_pkg::*;

    logic [DATA_W-1:0] used;

    // keep only the bits that belong to the character
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign used[g] = (g <= int'(len_code)) ? data[g] : 1'b0;
    end

    always_comb begin
        par_en  = 1'b1;
        par_bit = 1'b0;
        unique case (mode)
            PAR_ODD:   par_bit = ~^used;
            PAR_EVEN:  par_bit = ^used;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/async_tx_timer.sv
module async_tx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = tick && !clear && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/async_tx_fsm.sv
module async_tx_fsm #(
    parameter int DATA_W       = 8,
    parameter int CODE_W       = 3,
    parameter int OS_W         = 2,
    parameter int STOP_W       = 5,
    parameter int CNT_W        = 8,
    parameter int BASE_OS      = 16,
    parameter int STEPS        = 16,
    parameter int MAX_OS_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              brk_req,
    input  logic [OS_W-1:0]   cfg_os_rate,
    input  logic [CODE_W-1:0] cfg_char_len,
    input  logic [STOP_W-1:0] cfg_stop_len,
    input  logic              par_en_in,
    input  logic              par_bit_in,
    input  logic              timer_done,
    output logic              timer_clear,
    output logic [CNT_W-1:0]  timer_limit,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);
    import async_tx_pkg::*;

    localparam int STEP_TICKS = BASE_OS / STEPS;

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CODE_W-1:0] bit_idx_q;
    logic [CODE_W-1:0] len_q;
    logic [OS_W-1:0]   os_q;
    logic [STOP_W-1:0] stop_q;
    logic              par_en_q;
    logic              par_bit_q;
    logic [OS_W-1:0]   os_eff;
    logic              accept;
    logic [CNT_W-1:0]  bit_len;
    logic [CNT_W-1:0]  stop_len;

    assign os_eff = (int'(cfg_os_rate) > MAX_OS_SHIFT) ? OS_W'(MAX_OS_SHIFT) : cfg_os_rate;
    assign accept = (state_q == ST_IDLE) && !brk_req && in_valid;

    assign bit_len  = CNT_W'(BASE_OS) << os_q;
    assign stop_len = CNT_W'((CNT_W'(stop_q) + CNT_W'(1)) * (CNT_W'(STEP_TICKS) << os_q));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (brk_req)       state_d = ST_BREAK;
                else if (in_valid) state_d = ST_START;
            end
            ST_START: begin
                if (timer_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (timer_done && bit_idx_q == len_q)
                    state_d = par_en_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (timer_done) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (timer_done) state_d = brk_req ? ST_BREAK : ST_IDLE;
            end
            ST_BREAK: begin
                if (!brk_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // character datapath and configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_idx_q <= '0;
            len_q     <= '0;
            os_q      <= '0;
            stop_q    <= '0;
            par_en_q  <= 1'b0;
            par_bit_q <= 1'b0;
        end else if (accept) begin
            shreg_q   <= in_data;
            bit_idx_q <= '0;
            len_q     <= cfg_char_len;
            os_q      <= os_eff;
            stop_q    <= cfg_stop_len;
            par_en_q  <= par_en_in;
            par_bit_q <= par_bit_in;
        end else if (state_q == ST_DATA && timer_done) begin
            shreg_q   <= shreg_q >> 1;
            bit_idx_q <= bit_idx_q + CODE_W'(1);
        end
    end

    // outputs
    always_comb begin
        txd         = 1'b1;
        busy        = 1'b1;
        in_ready    = 1'b0;
        timer_clear = 1'b0;
        timer_limit = bit_len;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                in_ready    = !brk_req;
                timer_clear = 1'b1;
            end
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_bit_q;
            ST_STOP:   timer_limit = stop_len;
            ST_BREAK: begin
                txd         = 1'b0;
                timer_clear = 1'b1;
            end
            default: begin
                busy        = 1'b0;
                timer_clear = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
    parameter int DATA_W       = 8,
    parameter int BASE_OS      = 16,
    parameter int STEPS        = 16,
    parameter int MAX_OS_SHIFT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        os_tick,
    input  logic [1:0]                  cfg_os_rate,
    input  logic [$clog2(DATA_W)-1:0]   cfg_char_len,
    input  logic [2:0]                  cfg_parity,
    input  logic [$clog2(2*STEPS)-1:0]  cfg_stop_len,
    input  logic                        brk_req,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_valid,
    output logic                        in_ready,
    output logic                        txd,
    output logic                        busy
);
    localparam int CODE_W = $clog2(DATA_W);
    localparam int STOP_W = $clog2(2 * STEPS);
    localparam int CNT_W  = $clog2(2 * BASE_OS * (1 << MAX_OS_SHIFT) + 1);

    logic             par_en;
    logic             par_bit;
    logic             t_done;
    logic             t_clear;
    logic [CNT_W-1:0] t_limit;

    async_tx_parity #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_parity (
        .data     (in_data),
        .len_code (cfg_char_len),
        .mode     (cfg_parity),
        .par_en   (par_en),
        .par_bit  (par_bit)
    );

    async_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .clear (t_clear),
        .limit (t_limit),
        .done  (t_done)
    );

    async_tx_fsm #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .OS_W(2), .STOP_W(STOP_W),
        .CNT_W(CNT_W), .BASE_OS(BASE_OS), .STEPS(STEPS), .MAX_OS_SHIFT(MAX_OS_SHIFT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .brk_req      (brk_req),
        .cfg_os_rate  (cfg_os_rate),
        .cfg_char_len (cfg_char_len),
        .cfg_stop_len (cfg_stop_len),
        .par_en_in    (par_en),
        .par_bit_in   (par_bit),
        .timer_done   (t_done),
        .timer_clear  (t_clear),
        .timer_limit  (t_limit),
        .in_ready     (in_ready),
        .txd          (txd),
        .busy         (busy)
    );

endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic brk_req,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy
);
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!txd && busy));

    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!busy && !brk_req));

    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txd && !os_tick) |=> (busy && txd));

    p_break_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !busy) |=> (!txd && busy));

endmodule

bind async_char_tx async_char_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .brk_req  (brk_req),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/tb_async_char_tx.sv
`timescale 1ns/1ps
module tb_async_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       brk = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] os_sel = 2'd0;
    logic [2:0] clen = 3'd7;
    logic [2:0] par = 3'd0;
    logic [4:0] stop = 5'd15;
    logic [7:0] din = 8'h00;
    logic       in_ready, txd, busy;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    async_char_tx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_os_rate(os_sel),
        .cfg_char_len(clen), .cfg_parity(par), .cfg_stop_len(stop),
        .brk_req(brk), .in_data(din), .in_valid(in_valid),
        .in_ready(in_ready), .txd(txd), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one character; brk_at >= 0 raises break at that sample index
    task automatic send(input logic [7:0] d, input int cl, input int pm, input int sp,
                        input int os, input int brk_at, input bit scramble, input string req);
        int L     = 16 << ((os == 3) ? 2 : os);
        int nb    = cl + 1;
        bit pen   = (pm >= 1 && pm <= 4);
        int ones  = 0;
        bit pb    = 1'b0;
        int total;
        int bad_i = -1;
        int act   = 0;
        int exp   = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (pm)
            1: pb = (ones % 2 == 0);
            2: pb = (ones % 2 == 1);
            3: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        total = L * (1 + nb + (pen ? 1 : 0)) + (sp + 1) * (L / 16);
        @(negedge clk);
        din = d; clen = cl[2:0]; par = pm[2:0]; stop = sp[4:0]; os_sel = os[1:0];
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        din = ~d;
        if (scramble) begin clen = 3'd0; par = 3'd3; stop = 5'd0; os_sel = 2'd2; end
        for (int i = 0; i < total; i++) begin
            int e;
            if (i < L) e = 0;
            else if (i < L * (1 + nb)) e = int'(d[(i - L) / L]);
            else if (pen && i < L * (2 + nb)) e = int'(pb);
            else e = 1;
            if (brk_at == i) brk = 1'b1;
            if (bad_i < 0 && (txd !== e[0] || in_ready !== 1'b0 || busy !== 1'b1)) begin
                bad_i = i; act = int'(txd); exp = e;
            end
            @(negedge clk);
        end
        chk(bad_i < 0, req, $sformatf("line d=%h len=%0d par=%0d stop=%0d os=%0d sample %0d",
            d, cl, pm, sp, os, bad_i), act, exp);
        if (brk_at >= 0)
            chk(txd === 1'b0 && in_ready === 1'b0 && busy === 1'b1, "R9",
                "line low after stop {txd,rdy,busy}", int'({txd, in_ready, busy}), 1);
        else
            chk(txd === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R6",
                "ready right after stop {txd,rdy,busy}", int'({txd, in_ready, busy}), 6);
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
            "reset {txd,busy,rdy}", int'({txd, busy, in_ready}), 5);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R11: every length against every parity code
        for (int cl = 0; cl < 8; cl++)
            for (int pm = 0; pm < 5; pm++)
                send(8'hA5 ^ 8'(cl * 37 + pm * 11), cl, pm, 15, 0, -1, 1'b0, "R2 R3 R11");

        // R3: code 5 sends no parity bit
        send(8'h6B, 7, 5, 15, 0, -1, 1'b0, "R3");

        // R4: every stop code
        for (int sp = 0; sp < 32; sp++)
            send(8'h3C, 7, 0, sp, 0, -1, 1'b0, "R4");

        // R5: higher oversampling rates
        send(8'hC3, 7, 1, 0, 1, -1, 1'b0, "R5");
        send(8'h59, 4, 2, 31, 1, -1, 1'b0, "R5");
        send(8'h96, 7, 3, 7, 2, -1, 1'b0, "R5");
        send(8'h01, 0, 4, 16, 2, -1, 1'b0, "R5");
        send(8'h05, 2, 1, 3, 3, -1, 1'b0, "R5");

        // R10: configuration changed mid-character
        send(8'h4E, 6, 2, 20, 0, -1, 1'b1, "R10");

        // R9: break raised during data, character completes
        send(8'hB2, 7, 1, 9, 0, 40, 1'b0, "R9");
        @(negedge clk);
        brk = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R8",
            "release after break {txd,rdy,busy}", int'({txd, in_ready, busy}), 6);

        // R8: break from idle, offered character ignored
        brk = 1'b1; in_valid = 1'b1; din = 8'h00;
        @(negedge clk);
        chk(txd === 1'b0 && in_ready === 1'b0 && busy === 1'b1, "R8",
            "break entry {txd,rdy,busy}", int'({txd, in_ready, busy}), 1);
        begin
            bit held = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (txd !== 1'b0 || in_ready !== 1'b0) held = 1'b0;
            end
            chk(held, "R8", "break held low", int'(held), 1);
        end
        brk = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
                if (txd !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R8", "idle after break, no frame from held offer", int'(quiet), 1);
        end

        // R7: no oversampling pulses freezes the start bit
        os_tick = 1'b0;
        din = 8'h7E; clen = 3'd7; par = 3'd0; stop = 5'd15; os_sel = 2'd0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        begin
            bit frozen = 1'b1;
            int n = 0;
            for (int i = 0; i < 40; i++) begin
                if (txd !== 1'b0 || busy !== 1'b1) frozen = 1'b0;
                @(negedge clk);
            end
            chk(frozen, "R7", "start bit held without pulses", int'(frozen), 1);
            os_tick = 1'b1;
            while (busy === 1'b1 && n < 1000) begin
                @(negedge clk);
                n++;
            end
            chk(n == 160, "R7", "cycles to finish after pulses resume", n, 160);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule